// File: doc/BRIEF.md
# Stereo ADC Output Conditioning Path

This block sits between the decimation filters of a stereo audio ADC and the serial audio interface. It takes one signed 24-bit sample per channel on each strobe. It runs both channels through a shared high-pass filter configuration, optionally flips each channel's sign, and gates each channel with its own enable. A filtered pair appears on the outputs with a valid strobe two clocks after the input strobe.

The high-pass filter has three settings. It can be off, so samples pass untouched. In audio mode it is a fixed first-order DC blocker with a corner near 3.7 Hz. In application mode it is second order: two identical first-order sections in cascade, whose pole is picked from an eight-entry table by a 3-bit cut-off field. Any change to the filter settings clears the filter history. The block also registers an oversampling-rate select bit and returns it as an output, so the decimator and the rest of the chip can read it.

Top module: `adc_cond_path`

## Requirements
- R1: Each channel has its own enable, and both enables are 0 after reset. While a channel's enable is 0, its output is 0; the output is forced to 0 two clocks after the enable input is seen low.
- R2: Each channel has its own invert bit. At 1 the filtered sample is negated; the negation of -8388608 gives +8388607. At 0 the sample is unchanged.
- R3: With the filter enable at 0, the filter is bypassed and the output equals the input sample (before the invert and enable stages).
- R4: With the filter enabled and the mode bit at 0, each channel computes y[n] = sat(x[n] - x[n-1] + ((A*y[n-1]) >>> 22)), where A = 4192273 (Q2.22) and >>> is an arithmetic shift (floor).
- R5: With the mode bit at 1, two such sections run in cascade, and the second section takes the output of the first. Both use A = 4194304 - floor(F*549033/1000), where F in Hz is selected by the 3-bit cut field: 0:80, 1:100, 2:125, 3:160, 4:200, 5:250, 6:320, 7:400.
- R6: A change of the filter enable, the mode or the cut field zeroes all filter history. The first filtered sample after such a change therefore equals its input.
- R7: Every section result saturates to the range -8388608 to +8388607.
- R8: The output valid follows the input strobe by exactly 2 clocks. Between valid strobes, an enabled channel's output holds its last value.
- R9: The oversampling select bit (0 = 64x, 1 = 128x) appears on its output one clock later and resets to 0.
- R10: Control inputs take effect on a sample when they are stable from one clock before that sample's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_vld_i | input | 1 | Input sample strobe |
| left_i | input | 24 | Left sample, signed |
| right_i | input | 24 | Right sample, signed |
| en_l_i | input | 1 | Left channel enable |
| en_r_i | input | 1 | Right channel enable |
| inv_l_i | input | 1 | Left sign invert |
| inv_r_i | input | 1 | Right sign invert |
| hpf_en_i | input | 1 | High-pass filter enable |
| hpf_mode_i | input | 1 | 0 first-order fixed, 1 second-order selectable |
| hpf_cut_i | input | 3 | Second-order cut-off select |
| osr_sel_i | input | 1 | Oversampling select, 0 = 64x, 1 = 128x |
| vld_o | output | 1 | Output sample valid |
| left_o | output | 24 | Left output, signed |
| right_o | output | 24 | Right output, signed |
| osr_128_o | output | 1 | Registered oversampling select |

## Verification
The bench uses the default parameters: 24-bit samples, 22 fractional coefficient bits, 32-bit coefficient width and a 3-bit cut field. With these, all eight cut-off entries and both ends of the 24-bit range can be driven directly. Full-scale steps push the difference term past the sample range, so section saturation and the invert of the most negative value are reached with single samples. A model of the recursion written from the equations tracks long random runs across all modes and mode changes.

// File: rtl/adc_cond_pkg.sv
package adc_cond_pkg;
  localparam int SMP_W      = 24;
  localparam int COEF_FRAC  = 22;
  localparam int COEF_W     = 32;
  localparam int CUT_BITS   = 3;
  localparam int NUM_CH     = 2;
  localparam int FO_POLE    = 4192273;  // 3.7 Hz corner at 48 kHz, Q2.22
  localparam int POLE_SLOPE = 549033;   // 2^22 * 2*pi / 48000, times 1000

  typedef struct packed {
    logic                en;
    logic                mode;
    logic [CUT_BITS-1:0] cut;
  } hpf_cfg_t;

  function automatic int cut_hz(logic [CUT_BITS-1:0] idx);
    case (idx)
      3'd0:    return 80;
      3'd1:    return 100;
      3'd2:    return 125;
      3'd3:    return 160;
      3'd4:    return 200;
      3'd5:    return 250;
      3'd6:    return 320;
      default: return 400;
    endcase
  endfunction

  function automatic logic signed [COEF_W-1:0] pole_coef(logic [CUT_BITS-1:0] idx);
    return COEF_W'((1 << COEF_FRAC) - (cut_hz(idx) * POLE_SLOPE) / 1000);
  endfunction
endpackage

// File: rtl/adc_hpf_section.sv
module adc_hpf_section #(
  parameter int DW   = 24,
  parameter int FRAC = 22,
  parameter int CFW  = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  step_i,
  input  logic signed [DW-1:0]  x_i,
  input  logic signed [CFW-1:0] coef_i,
  output logic signed [DW-1:0]  y_o
);
  localparam int AW = DW + CFW;
  localparam logic signed [AW-1:0] MAX_V = (AW'(1) <<< (DW-1)) - AW'(1);
  localparam logic signed [AW-1:0] MIN_V = ~MAX_V;

  logic signed [DW-1:0] x1_q, y1_q;
  logic signed [AW-1:0] prod, acc;

  always_comb begin
    prod = $signed(AW'(coef_i)) * $signed(AW'(y1_q));
    acc  = $signed(AW'(x_i)) - $signed(AW'(x1_q)) + (prod >>> FRAC);
    if (acc > MAX_V)      y_o = MAX_V[DW-1:0];
    else if (acc < MIN_V) y_o = MIN_V[DW-1:0];
    else                  y_o = acc[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q <= '0;
      y1_q <= '0;
    end else if (clr_i) begin
      x1_q <= '0;
      y1_q <= '0;
    end else if (step_i) begin
      x1_q <= x_i;
      y1_q <= y_o;
    end
  end
endmodule

// File: rtl/adc_cond_chan.sv
module adc_cond_chan #(
  parameter int DW      = 24,
  parameter int FRAC    = 22,
  parameter int CFW     = 32,
  parameter int FO_COEF = 4192273
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  step_i,
  input  logic signed [DW-1:0]  x_i,
  input  logic                  hpf_en_i,
  input  logic                  mode_i,
  input  logic signed [CFW-1:0] coef_i,
  input  logic                  inv_i,
  input  logic                  en_i,
  output logic signed [DW-1:0]  y_o
);
  localparam logic signed [DW-1:0] MAX_S = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MIN_S = {1'b1, {(DW-1){1'b0}}};

  logic signed [CFW-1:0] coef_a;
  logic signed [DW-1:0]  y_a, y_b, filt, negd;

  assign coef_a = mode_i ? coef_i : CFW'(FO_COEF);

  adc_hpf_section #(.DW(DW), .FRAC(FRAC), .CFW(CFW)) u_sec_a (
    .clk_i, .rst_ni, .clr_i, .step_i,
    .x_i(x_i), .coef_i(coef_a), .y_o(y_a)
  );

  adc_hpf_section #(.DW(DW), .FRAC(FRAC), .CFW(CFW)) u_sec_b (
    .clk_i, .rst_ni, .clr_i,
    .step_i(step_i & mode_i),
    .x_i(y_a), .coef_i(coef_i), .y_o(y_b)
  );

  always_comb begin
    if (!hpf_en_i)   filt = x_i;
    else if (mode_i) filt = y_b;
    else             filt = y_a;
    negd = (filt == MIN_S) ? MAX_S : -filt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     y_o <= '0;
    else if (!en_i)  y_o <= '0;
    else if (step_i) y_o <= inv_i ? negd : filt;
  end
endmodule

// File: rtl/adc_cond_path.sv
module adc_cond_path
  import adc_cond_pkg::*;
#(
  parameter int DW      = SMP_W,
  parameter int FRAC    = COEF_FRAC,
  parameter int CFW     = COEF_W,
  parameter int FO_COEF = FO_POLE
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_vld_i,
  input  logic [DW-1:0]       left_i,
  input  logic [DW-1:0]       right_i,
  input  logic                en_l_i,
  input  logic                en_r_i,
  input  logic                inv_l_i,
  input  logic                inv_r_i,
  input  logic                hpf_en_i,
  input  logic                hpf_mode_i,
  input  logic [CUT_BITS-1:0] hpf_cut_i,
  input  logic                osr_sel_i,
  output logic                vld_o,
  output logic [DW-1:0]       left_o,
  output logic [DW-1:0]       right_o,
  output logic                osr_128_o
);
  hpf_cfg_t              cfg_in, cfg_q;
  logic [NUM_CH-1:0]     en_q, inv_q;
  logic                  osr_q, s1_vld_q, vld_q;
  logic signed [DW-1:0]  x_q  [NUM_CH];
  logic signed [DW-1:0]  x_in [NUM_CH];
  logic signed [DW-1:0]  y_ch [NUM_CH];
  logic signed [CFW-1:0] cut_coef;
  logic                  clr;

  assign cfg_in  = '{en: hpf_en_i, mode: hpf_mode_i, cut: hpf_cut_i};
  assign x_in[0] = left_i;
  assign x_in[1] = right_i;
  // history is dropped on any filter setting change and kept empty while bypassed
  assign clr      = (cfg_in != cfg_q) || !cfg_q.en;
  assign cut_coef = CFW'(pole_coef(cfg_q.cut));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      en_q     <= '0;
      inv_q    <= '0;
      osr_q    <= 1'b0;
      s1_vld_q <= 1'b0;
      vld_q    <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) x_q[i] <= '0;
    end else begin
      cfg_q    <= cfg_in;
      en_q     <= {en_r_i, en_l_i};
      inv_q    <= {inv_r_i, inv_l_i};
      osr_q    <= osr_sel_i;
      s1_vld_q <= smp_vld_i;
      vld_q    <= s1_vld_q;
      if (smp_vld_i)
        for (int i = 0; i < NUM_CH; i++) x_q[i] <= x_in[i];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    adc_cond_chan #(.DW(DW), .FRAC(FRAC), .CFW(CFW), .FO_COEF(FO_COEF)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr),
      .step_i   (s1_vld_q),
      .x_i      (x_q[ch]),
      .hpf_en_i (cfg_q.en),
      .mode_i   (cfg_q.mode),
      .coef_i   (cut_coef),
      .inv_i    (inv_q[ch]),
      .en_i     (en_q[ch]),
      .y_o      (y_ch[ch])
    );
  end

  assign left_o    = y_ch[0];
  assign right_o   = y_ch[1];
  assign vld_o     = vld_q;
  assign osr_128_o = osr_q;
endmodule

// File: rtl/adc_cond_path_chk.sv
module adc_cond_path_chk #(
  parameter int DW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          smp_vld_i,
  input logic [DW-1:0] left_i,
  input logic [DW-1:0] right_i,
  input logic          en_l_i,
  input logic          en_r_i,
  input logic          inv_l_i,
  input logic          inv_r_i,
  input logic          hpf_en_i,
  input logic          osr_sel_i,
  input logic          vld_o,
  input logic [DW-1:0] left_o,
  input logic [DW-1:0] right_o,
  input logic          osr_128_o
);
  localparam logic [DW-1:0] MIN_S = {1'b1, {(DW-1){1'b0}}};
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  AST_VLD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q >= 2'd2 |-> vld_o == $past(smp_vld_i, 2)); // R8
  AST_HOLD_L: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q >= 2'd2 && !vld_o && $past(en_l_i, 2) |-> $stable(left_o)); // R8
  AST_HOLD_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q >= 2'd2 && !vld_o && $past(en_r_i, 2) |-> $stable(right_o)); // R8
  AST_OFF_ZERO_L: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q >= 2'd2 && !$past(en_l_i, 2) |-> left_o == '0); // R1
  AST_OFF_ZERO_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q >= 2'd2 && !$past(en_r_i, 2) |-> right_o == '0); // R1
  AST_INV_NO_MIN_L: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q >= 2'd2 && vld_o && $past(inv_l_i, 2) && $past(en_l_i, 2) |-> left_o != MIN_S); // R2
  AST_INV_NO_MIN_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q >= 2'd2 && vld_o && $past(inv_r_i, 2) && $past(en_r_i, 2) |-> right_o != MIN_S); // R2
  AST_BYPASS_L: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q >= 2'd2 && vld_o && !$past(hpf_en_i, 2) && !$past(inv_l_i, 2) && $past(en_l_i, 2)
    |-> left_o == $past(left_i, 2)); // R3
  AST_BYPASS_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q >= 2'd2 && vld_o && !$past(hpf_en_i, 2) && !$past(inv_r_i, 2) && $past(en_r_i, 2)
    |-> right_o == $past(right_i, 2)); // R3
  AST_OSR_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_q >= 2'd1 |-> osr_128_o == $past(osr_sel_i)); // R9
endmodule

bind adc_cond_path adc_cond_path_chk #(.DW(DW)) u_chk (.*);

// File: tb/adc_cond_path_bench.sv
`timescale 1ns/1ps
module adc_cond_path_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_vld = 1'b0;
  logic [23:0] left_i = '0, right_i = '0;
  logic        en_l = 0, en_r = 0, inv_l = 0, inv_r = 0;
  logic        hpf_en = 0, hpf_mode = 0, osr_sel = 0;
  logic [2:0]  hpf_cut = '0;
  logic        vld_o, osr_o;
  logic [23:0] left_o, right_o;

  int total = 0, bad = 0;
  bit done = 0;

  longint xa1[2], ya1[2], xb1[2], yb1[2], expv[2];

  always #4 clk = ~clk;

  adc_cond_path u_adc_cond_path (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(smp_vld),
    .left_i(left_i), .right_i(right_i),
    .en_l_i(en_l), .en_r_i(en_r), .inv_l_i(inv_l), .inv_r_i(inv_r),
    .hpf_en_i(hpf_en), .hpf_mode_i(hpf_mode), .hpf_cut_i(hpf_cut), .osr_sel_i(osr_sel),
    .vld_o(vld_o), .left_o(left_o), .right_o(right_o), .osr_128_o(osr_o)
  );

  function automatic longint sat24(longint v);
    if (v > 8388607)  return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  function automatic longint pole(int c);
    int hz[8] = '{80, 100, 125, 160, 200, 250, 320, 400};
    return 4194304 - (longint'(hz[c]) * 549033) / 1000;
  endfunction

  function automatic longint sect(longint x, longint x1, longint y1, longint a);
    return sat24(x - x1 + ((a * y1) >>> 22));
  endfunction

  function automatic longint s24(logic [23:0] v);
    return longint'($signed(v));
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_model();
    for (int c = 0; c < 2; c++) begin
      xa1[c] = 0; ya1[c] = 0; xb1[c] = 0; yb1[c] = 0;
    end
  endtask

  task automatic set_ctrl(bit el, bit er, bit il, bit ir, bit he, bit hm, bit [2:0] hc);
    @(negedge clk);
    if (he != hpf_en || hm != hpf_mode || hc != hpf_cut || !he) clear_model();
    en_l = el; en_r = er; inv_l = il; inv_r = ir;
    hpf_en = he; hpf_mode = hm; hpf_cut = hc;
    if (!el) expv[0] = 0;
    if (!er) expv[1] = 0;
  endtask

  task automatic send(longint l, longint r, string req);
    longint xin[2];
    longint f, ya, yb;
    bit en[2], inv[2];
    xin[0] = l; xin[1] = r;
    en[0] = en_l; en[1] = en_r; inv[0] = inv_l; inv[1] = inv_r;
    @(negedge clk);
    smp_vld = 1'b1; left_i = l[23:0]; right_i = r[23:0];
    for (int c = 0; c < 2; c++) begin
      if (!hpf_en) f = xin[c];
      else begin
        ya = sect(xin[c], xa1[c], ya1[c], hpf_mode ? pole(int'(hpf_cut)) : 64'd4192273);
        xa1[c] = xin[c]; ya1[c] = ya;
        f = ya;
        if (hpf_mode) begin
          yb = sect(ya, xb1[c], yb1[c], pole(int'(hpf_cut)));
          xb1[c] = ya; yb1[c] = yb;
          f = yb;
        end
      end
      if (inv[c]) f = (f == -8388608) ? 8388607 : -f;
      expv[c] = en[c] ? f : 0;
    end
    @(negedge clk);
    smp_vld = 1'b0;
    @(negedge clk);
    chk(vld_o === 1'b1, "R8 vld", longint'(vld_o), 1);
    chk(s24(left_o) == expv[0], {req, " left"}, s24(left_o), expv[0]);
    chk(s24(right_o) == expv[1], {req, " right"}, s24(right_o), expv[1]);
  endtask

  function automatic longint rnd24(int kind);
    case (kind)
      0: return s24(24'($urandom()));
      1: return longint'($signed(12'($urandom())));
      2: return ($urandom() & 1) ? 8388607 : -8388608;
      default: return 1000000 + longint'($urandom_range(0, 500));
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_a0c3));
    clear_model(); expv[0] = 0; expv[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(left_o == 0 && right_o == 0, "R1 reset outputs", s24(left_o), 0);
    chk(vld_o == 0, "R8 reset valid", longint'(vld_o), 0);
    chk(osr_o == 0, "R9 reset osr", longint'(osr_o), 0);

    // R1: disabled channels stay zero
    send(1234, -5678, "R1");
    set_ctrl(1, 0, 0, 0, 0, 0, 3'd0);
    send(4321, 999, "R1");

    // R3: bypass passthrough
    set_ctrl(1, 1, 0, 0, 0, 0, 3'd0);
    send(5, -7, "R3");
    send(8388607, -8388608, "R3");

    // R2: invert with saturation of the most negative value
    set_ctrl(1, 1, 1, 1, 0, 0, 3'd0);
    send(-8388608, 100, "R2");
    chk(s24(left_o) == 8388607, "R2 neg min", s24(left_o), 8388607);
    @(negedge clk);
    chk(vld_o == 0, "R8 valid single", longint'(vld_o), 0);
    chk(s24(left_o) == 8388607, "R8 hold", s24(left_o), 8388607);

    // R9: oversampling select
    @(negedge clk); osr_sel = 1'b1;
    @(negedge clk);
    chk(osr_o == 1, "R9 osr set", longint'(osr_o), 1);

    // R4: first-order DC blocker
    set_ctrl(1, 1, 0, 1, 1, 0, 3'd0);
    for (int i = 0; i < 6; i++) send(100000, -250000, "R4");

    // R7: full-scale step saturates the section
    send(-8388608, 8388607, "R7");
    send(8388607, -8388608, "R7");
    chk(s24(left_o) == 8388607, "R7 sat high", s24(left_o), 8388607);

    // R5: second-order, every cut entry
    for (int c = 0; c < 8; c++) begin
      set_ctrl(1, 1, 0, 0, 1, 1, 3'(c));
      for (int i = 0; i < 4; i++) send(rnd24(i % 4), rnd24((i + 1) % 4), "R5");
    end

    // R6: first output after a cut change equals the input
    set_ctrl(1, 1, 0, 0, 1, 1, 3'd2);
    send(300000, -300000, "R6");
    send(-20000, 40000, "R6");
    set_ctrl(1, 1, 0, 0, 1, 1, 3'd5);
    send(777777, -123456, "R6");
    chk(s24(left_o) == 777777, "R6 cleared history", s24(left_o), 777777);
    set_ctrl(1, 1, 0, 0, 1, 0, 3'd5);
    send(-654321, 11, "R6");
    chk(s24(left_o) == -654321, "R6 mode change", s24(left_o), -654321);

    // R10 with random control and data
    for (int b = 0; b < 40; b++) begin
      set_ctrl(1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 7) != 0),
               1'($urandom()), 1'($urandom()), 1'($urandom_range(0, 4) != 0),
               1'($urandom()), 3'($urandom()));
      for (int i = 0; i < 10; i++)
        send(rnd24(int'($urandom_range(0, 3))), rnd24(int'($urandom_range(0, 3))), "R10");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule